// File: doc/BRIEF.md
# Burst Address Counter Unit

This block is the per-port address source placed ahead of a memory decoder. Each cycle it picks the address for the access in progress from one of four operations: clear to zero, load of the external address, step to the next address, or hold of the stored address. It also keeps a counter register, so later cycles can walk through memory without new external addresses.

The three controls are active low. Clear has the highest priority, load comes second and step third. When all three are high, the unit holds. The access address is combinational from the controls, the external address and the counter register. The memory can therefore register it on the same clock edge that updates the counter, and clear or load costs no extra cycle. Stepping covers the whole address space and wraps around. The unit has no chip-select input, so counting goes on whether or not the port is selected.

Top module: `burst_addr_unit`

## Requirements
- R1: While `cnt_clr_n` is 0, `acc_addr` is 0 and the counter holds 0 after the next rising edge, whatever `strobe_n` and `cnt_en_n` are.
- R2: While `cnt_clr_n` is 1 and `strobe_n` is 0, `acc_addr` equals `ext_addr` in the same cycle, and that value is stored in the counter at the next rising edge.
- R3: While `cnt_clr_n` and `strobe_n` are 1 and `cnt_en_n` is 0, `acc_addr` is the stored counter value plus one, and that value is stored at the next rising edge.
- R4: `cnt_en_n` has no effect in a cycle where `strobe_n` or `cnt_clr_n` is 0.
- R5: While all three controls are 1, `acc_addr` equals the stored counter value, the counter keeps its value and `ext_addr` is ignored.
- R6: Stepping from the all-ones address gives address 0. A run of 2^AW steps returns to the starting address.
- R7: A clear or load cycle is itself an access cycle. A step in the cycle right after a clear gives address 1, and a step right after a load of A gives A+1.
- R8: While `rst_n` is 0, the counter is 0 at once, so a hold cycle shows `acc_addr` = 0. After `rst_n` rises, the counter ignores the controls for two rising edges (the synchronizer depth) and then responds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_addr | input | AW | External address presented by the port |
| strobe_n | input | 1 | Active-low address strobe: load `ext_addr` |
| cnt_en_n | input | 1 | Active-low count enable: step the counter |
| cnt_clr_n | input | 1 | Active-low counter clear to address 0 |
| acc_addr | output | AW | Address used by the access in the current cycle |

## Verification
The hardest case to reach from the ports is the wrap from the top of the address space. After a clear it takes 2^AW unbroken step cycles, and every one of them must produce the right address, not just the final one. The stimulus covers this in two ways. It loads the all-ones address and steps once, and it also runs a full sweep from zero through every address back to zero while changing `ext_addr` every cycle to show that it is ignored. Priority collisions, where clear, strobe and enable are all low together, are driven on purpose right before step cycles, so that a wrong stored value shows up at once.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  // Operation selected for the current cycle, highest priority last.
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_STEP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } burst_op_e;
endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/burst_op_decode.sv
module burst_op_decode
  import burst_addr_pkg::*;
(
  input  logic      strobe_n,
  input  logic      cnt_en_n,
  input  logic      cnt_clr_n,
  output burst_op_e op
);
  always_comb begin
    if (!cnt_clr_n)     op = OP_CLEAR;
    else if (!strobe_n) op = OP_LOAD;
    else if (!cnt_en_n) op = OP_STEP;
    else                op = OP_HOLD;
  end
endmodule

// File: rtl/burst_addr_select.sv
module burst_addr_select
  import burst_addr_pkg::*;
#(
  parameter int AW = 13
) (
  input  burst_op_e        op,
  input  logic [AW-1:0]    ext_addr,
  input  logic [AW-1:0]    cnt_q,
  output logic [AW-1:0]    sel_addr
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_comb begin
    unique case (op)
      OP_CLEAR: sel_addr = '0;
      OP_LOAD:  sel_addr = ext_addr;
      OP_STEP:  sel_addr = cnt_q + ONE;
      default:  sel_addr = cnt_q;
    endcase
  end
endmodule

// File: rtl/burst_cnt_reg.sv
module burst_cnt_reg
  import burst_addr_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  burst_op_e     op,
  input  logic [AW-1:0] sel_addr,
  output logic [AW-1:0] cnt_q
);
  logic          cnt_en;
  logic [AW-1:0] cnt_d;

  always_comb begin
    cnt_en = (op != OP_HOLD);
    cnt_d  = sel_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/burst_addr_unit.sv
module burst_addr_unit
  import burst_addr_pkg::*;
#(
  parameter int AW          = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ext_addr,
  input  logic          strobe_n,
  input  logic          cnt_en_n,
  input  logic          cnt_clr_n,
  output logic [AW-1:0] acc_addr
);
  logic          rst_sync_n;
  burst_op_e     op;
  logic [AW-1:0] cnt_q;
  logic [AW-1:0] sel_addr;

  burst_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  burst_op_decode u_dec (
    .strobe_n  (strobe_n),
    .cnt_en_n  (cnt_en_n),
    .cnt_clr_n (cnt_clr_n),
    .op        (op)
  );

  burst_addr_select #(.AW(AW)) u_sel (
    .op       (op),
    .ext_addr (ext_addr),
    .cnt_q    (cnt_q),
    .sel_addr (sel_addr)
  );

  burst_cnt_reg #(.AW(AW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .op       (op),
    .sel_addr (sel_addr),
    .cnt_q    (cnt_q)
  );

  assign acc_addr = sel_addr;
endmodule

// File: rtl/burst_addr_unit_chk.sv
module burst_addr_unit_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic [AW-1:0] ext_addr,
  input logic          strobe_n,
  input logic          cnt_en_n,
  input logic          cnt_clr_n,
  input logic [AW-1:0] acc_addr,
  input logic [AW-1:0] cnt_q
);
  localparam logic [AW-1:0] ONE = AW'(1);

  // R1
  clr_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !cnt_clr_n |-> acc_addr == '0);

  // R1
  clr_cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !cnt_clr_n |=> cnt_q == '0);

  // R2
  load_pass_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cnt_clr_n && !strobe_n) |-> acc_addr == ext_addr);

  // R2
  load_store_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cnt_clr_n && !strobe_n) |=> cnt_q == $past(ext_addr));

  // R3
  step_addr_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cnt_clr_n && strobe_n && !cnt_en_n) |-> acc_addr == cnt_q + ONE);

  // R5
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cnt_clr_n && strobe_n && cnt_en_n) |-> acc_addr == cnt_q);

  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cnt_clr_n && strobe_n && cnt_en_n) |=> $stable(cnt_q));

  // R6
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cnt_clr_n && strobe_n && !cnt_en_n && (&cnt_q)) |-> acc_addr == '0);

  // R7
  access_tracked_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |=> cnt_q == $past(acc_addr));
endmodule

bind burst_addr_unit burst_addr_unit_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_sync_n),
  .ext_addr  (ext_addr),
  .strobe_n  (strobe_n),
  .cnt_en_n  (cnt_en_n),
  .cnt_clr_n (cnt_clr_n),
  .acc_addr  (acc_addr),
  .cnt_q     (cnt_q)
);

// File: tb/burst_addr_unit_test.sv
module burst_addr_unit_test;
  localparam int AW         = 13;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 1 << AW;

  typedef struct {
    logic [AW-1:0] exp;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] ext_addr;
  logic          strobe_n;
  logic          cnt_en_n;
  logic          cnt_clr_n;
  logic [AW-1:0] acc_addr;

  int            n_run  = 0;
  int            n_fail = 0;
  logic [AW-1:0] model  = '0;
  item_t         sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_unit #(.AW(AW)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_addr  (ext_addr),
    .strobe_n  (strobe_n),
    .cnt_en_n  (cnt_en_n),
    .cnt_clr_n (cnt_clr_n),
    .acc_addr  (acc_addr)
  );

  task automatic check(input logic [AW-1:0] got, input logic [AW-1:0] exp, input string tag);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: acc_addr=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // Driver: applies one cycle of controls and queues the expected address.
  task automatic drive(input logic [AW-1:0] a, input logic s, input logic e,
                       input logic c, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    ext_addr  = a;
    strobe_n  = s;
    cnt_en_n  = e;
    cnt_clr_n = c;
    if (!c)      model = '0;
    else if (!s) model = a;
    else if (!e) model = model + AW'(1);
    it.exp = model;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compares one queued item per cycle, away from the rising edge.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(acc_addr, it.exp, it.tag);
      end
    end
  end

  task automatic drain();
    while (sb_q.size() > 0) @(negedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext_addr = 13'h1abc; strobe_n = 1'b1; cnt_en_n = 1'b1; cnt_clr_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(acc_addr, '0, "R8 power-on counter zero");
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    drive(13'h0f0f, 1, 1, 1, "R5 hold after reset");
    drive(13'h0155, 0, 1, 1, "R2 load external");
    drive(13'h1fff, 1, 1, 1, "R5 hold ignores ext_addr");
    drive(13'h0000, 1, 0, 1, "R3 step");
    drive(13'h0aaa, 1, 0, 1, "R3 step again");
    drive(13'h0aaa, 1, 1, 1, "R5 hold after step");
    drive(13'h0400, 0, 0, 1, "R4 enable ignored under load");
    drive(13'h0000, 1, 0, 1, "R7 step after load");
    drive(13'h0777, 0, 0, 0, "R1 clear beats load and enable");
    drive(13'h0777, 1, 0, 1, "R7 step after clear gives 1");
    drive(13'h0321, 1, 0, 0, "R4 enable ignored under clear");
    drive(13'h0321, 1, 1, 1, "R1 counter left at zero");
    drive(13'h1fff, 0, 1, 1, "R2 load all ones");
    drive(13'h0000, 1, 0, 1, "R6 step wraps to zero");
    drive(13'h0000, 1, 0, 1, "R6 step after wrap");
    drive(13'h0000, 1, 1, 0, "R1 clear before sweep");
    for (int i = 0; i < DEPTH; i++)
      drive(AW'(i * 37), 1, 0, 1, "R6 full sweep step");
    drive(13'h1234, 1, 1, 1, "R6 sweep returns to start");
    drive(13'h0bcd, 0, 1, 1, "R2 load before async reset");
    drain();

    @(negedge clk); #1;
    strobe_n = 1'b1; cnt_en_n = 1'b1; cnt_clr_n = 1'b1;
    rst_n = 1'b0;
    #1 check(acc_addr, '0, "R8 async reset clears at once");
    @(posedge clk); #1 rst_n = 1'b1;
    // Controls during the synchronizer window must be ignored.
    strobe_n = 1'b0; ext_addr = 13'h0999;
    @(posedge clk); #1;
    @(negedge clk);
    check(acc_addr, 13'h0999, "R2 load shown combinationally in sync window");
    @(posedge clk); #1 strobe_n = 1'b1;
    #1 check(acc_addr, '0, "R8 counter ignored load during sync window");
    model = '0;
    drive(13'h0000, 1, 0, 1, "R8 step after sync release");
    drive(13'h0000, 1, 0, 1, "R3 step after sync release");
    drain();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule